// File: doc/BRIEF.md
# Prescaled down-counting timer

This block is a general-purpose interval timer. An 8-bit main counter counts down, and a 7-bit prescaler that also counts down paces it. The prescaler takes its input from one of two sources. The first is an internal divide-by-12 of the system clock. The second is an external timer pin, which passes through a synchronizer before use. A 3-bit tap field picks what steps the main counter: either the raw prescaler input, or one of the prescaler's own bits. Each bit further along halves the rate.

All edges are detected in the system clock domain. No derived signal is used as a clock.

Software reaches three registers over a simple synchronous bus: the counter, the prescaler and a control/status register. A zero flag is set when the counter decrements to zero. The flag and an enable bit together drive one interrupt output. The counter wraps and keeps counting, and the flag stays set until software writes it back to 0. A run bit starts and stops the block. While it is clear, the prescaler is parked at all ones and the counter is frozen.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the counter reads 00h, the control register reads 00h, the prescaler reads 7Fh and `irq` is 0.
- R2: Address 0 selects the counter, address 1 the prescaler and address 2 the control register. Reads are zero-extended to 8 bits. A counter write loads the written value on the next clock, and it wins over a decrement in the same cycle.
- R3: While the run bit is 1, the prescaler decrements by one on each rising edge of its input and wraps from 00h to 7Fh.
- R4: Control bit 4 picks the prescaler input. When it is 1, the input is the timer pin after a two-stage synchronizer. When it is 0, the input is the system clock divided by 12, which gives one rising edge every 12 cycles.
- R5: Control bits 2:0 (the tap select) choose what steps the counter. Value 0 steps the counter once per prescaler input edge. Value k from 1 to 7 uses prescaler bit k-1. Starting from a prescaler of 7Fh, this steps the counter once every 2^k input edges.
- R6: While control bit 3 (run) is 0, the prescaler reads 7Fh, the counter does not decrement, and writes to the prescaler are ignored.
- R7: While run is 1, a prescaler write loads any value from 00h to 7Fh.
- R8: When a decrement takes the counter to 00h, control bit 7 (zero flag) becomes 1. The next decrement wraps the counter to FFh and the flag stays 1. Only a control write with bit 7 at 0 clears the flag. If a set event and such a write occur in the same cycle, the set event wins.
- R9: `irq` is 1 exactly when the zero flag and control bit 6 (interrupt enable) are both 1. Control bit 5 is a spare mode bit that is stored and read back.
- R10: Without a counter write, the counter either holds or drops by exactly one from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_pin | input | 1 | External prescaler input, asynchronous |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on a few assumptions about the inputs. The bus holds steady between clock edges, and `tmr_pin` may change at any time, because the synchronizer absorbs it. The tap select should not change while run is 1: switching taps mid-run can create a spurious rising edge, and the checks on counter stepping do not model that. The stimulus respects this by always writing a new tap select with run at 0 and only then setting run. It also holds each pin level for four cycles, so every pulse passes the synchronizer and is seen as exactly one edge.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
   localparam int DATA_W = 8;

   typedef enum logic [1:0] {
      ADDR_COUNT = 2'd0,
      ADDR_PRESC = 2'd1,
      ADDR_CTRL  = 2'd2
   } tdt_addr_e;

   localparam int BIT_ZF   = 7;
   localparam int BIT_IE   = 6;
   localparam int BIT_MODE = 5;
   localparam int BIT_EXT  = 4;
   localparam int BIT_RUN  = 3;
endpackage

// File: rtl/tdt_clk_src.sv
module tdt_clk_src #(
   parameter int DIV_N  = 12,
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin_i,
   input  logic use_ext_i,
   output logic src_lvl_o
);
   localparam int DW = (DIV_N > 1) ? $clog2(DIV_N) : 1;
   localparam logic [DW-1:0] LAST = DW'(DIV_N - 1);
   localparam logic [DW-1:0] HALF = DW'(DIV_N / 2);

   generate
      if (DIV_N < 2) begin : g_bad_div
         $error("DIV_N must be at least 2");
      end
      if (SYNC_N < 2) begin : g_bad_sync
         $error("SYNC_N must be at least 2");
      end
   endgenerate

   logic [DW-1:0]     div_q;
   logic [SYNC_N-1:0] sync_q;
   logic              int_lvl;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q  <= '0;
         sync_q <= '0;
      end else begin
         div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
         sync_q <= {sync_q[SYNC_N-2:0], pin_i};
      end
   end

   assign int_lvl   = (div_q >= HALF);
   assign src_lvl_o = use_ext_i ? sync_q[SYNC_N-1] : int_lvl;

   assert_div_range_R4: assert property (@(posedge clk) disable iff (rst)
      div_q <= LAST);
endmodule

// File: rtl/tdt_prescaler.sv
module tdt_prescaler #(
   parameter int PSC_W = 7,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             src_lvl_i,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             wr_i,
   input  logic [PSC_W-1:0] wdata_i,
   output logic [PSC_W-1:0] psc_o,
   output logic             tap_rise_o
);
   localparam int NTAP = 2 ** SEL_W;

   generate
      if (PSC_W > NTAP - 1) begin : g_bad_sel
         $error("SEL_W too narrow to reach every prescaler bit");
      end
   endgenerate

   logic [PSC_W-1:0] psc_q;
   logic             src_q, tap_q, src_rise;
   logic [NTAP-1:0]  taps;
   logic             tap_lvl;

   genvar gi;
   generate
      for (gi = 0; gi < NTAP; gi++) begin : g_tap
         if (gi == 0) begin : g_raw
            assign taps[gi] = src_lvl_i;
         end else if (gi <= PSC_W) begin : g_bit
            assign taps[gi] = psc_q[gi-1];
         end else begin : g_none
            assign taps[gi] = 1'b0;
         end
      end
   endgenerate

   assign src_rise = src_lvl_i & ~src_q;
   assign tap_lvl  = taps[sel_i];

   always_ff @(posedge clk) begin
      if (rst) begin
         psc_q <= '1;
         src_q <= 1'b0;
         tap_q <= 1'b1;
      end else begin
         src_q <= src_lvl_i;
         tap_q <= tap_lvl;
         if (!run_i)        psc_q <= '1;
         else if (wr_i)     psc_q <= wdata_i;
         else if (src_rise) psc_q <= psc_q - 1'b1;
      end
   end

   assign psc_o      = psc_q;
   assign tap_rise_o = tap_lvl & ~tap_q;

   assert_parked_R6: assert property (@(posedge clk) disable iff (rst)
      !run_i |=> psc_q == '1);
   assert_psc_step_R3: assert property (@(posedge clk) disable iff (rst)
      (run_i && !wr_i) |=> (psc_q == $past(psc_q) || psc_q == $past(psc_q) - 1'b1));
   assert_psc_load_R7: assert property (@(posedge clk) disable iff (rst)
      (run_i && wr_i) |=> psc_q == $past(wdata_i));
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run_i,
   input  logic             tap_rise_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_zero_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step       = run_i & tap_rise_i & ~wr_i;
   assign hit_zero_o = step & (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (wr_i) cnt_q <= wdata_i;
      else if (step) cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_o = cnt_q;

   assert_wr_load_R2: assert property (@(posedge clk) disable iff (rst)
      wr_i |=> cnt_q == $past(wdata_i));
   assert_single_step_R10: assert property (@(posedge clk) disable iff (rst)
      !wr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
   assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
      (!run_i && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer #(
   parameter int CNT_W  = 8,
   parameter int PSC_W  = 7,
   parameter int SEL_W  = 3,
   parameter int DIV_N  = 12,
   parameter int SYNC_N = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tmr_pin,
   input  logic [1:0] bus_addr,
   input  logic       bus_wr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       irq
);
   import tdt_pkg::*;

   generate
      if (CNT_W > DATA_W || PSC_W >= DATA_W) begin : g_bad_w
         $error("counter or prescaler wider than the bus");
      end
      if (SEL_W > BIT_RUN) begin : g_bad_sel
         $error("tap select overlaps the run bit");
      end
   endgenerate

   logic             zf_q, ie_q, mode_q, ext_q, run_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt;
   logic [PSC_W-1:0] psc;
   logic             src_lvl, tap_rise, hit_zero;
   logic             wr_cnt, wr_psc, wr_ctrl;

   assign wr_cnt  = bus_wr && (bus_addr == ADDR_COUNT);
   assign wr_psc  = bus_wr && (bus_addr == ADDR_PRESC);
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);

   tdt_clk_src #(.DIV_N(DIV_N), .SYNC_N(SYNC_N)) src_i (
      .clk(clk), .rst(rst), .pin_i(tmr_pin), .use_ext_i(ext_q),
      .src_lvl_o(src_lvl));

   tdt_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) psc_i (
      .clk(clk), .rst(rst), .src_lvl_i(src_lvl), .run_i(run_q), .sel_i(sel_q),
      .wr_i(wr_psc), .wdata_i(bus_wdata[PSC_W-1:0]), .psc_o(psc),
      .tap_rise_o(tap_rise));

   tdt_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst(rst), .run_i(run_q), .tap_rise_i(tap_rise),
      .wr_i(wr_cnt), .wdata_i(bus_wdata[CNT_W-1:0]), .cnt_o(cnt),
      .hit_zero_o(hit_zero));

   always_ff @(posedge clk) begin
      if (rst) begin
         zf_q   <= 1'b0;
         ie_q   <= 1'b0;
         mode_q <= 1'b0;
         ext_q  <= 1'b0;
         run_q  <= 1'b0;
         sel_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            ie_q   <= bus_wdata[BIT_IE];
            mode_q <= bus_wdata[BIT_MODE];
            ext_q  <= bus_wdata[BIT_EXT];
            run_q  <= bus_wdata[BIT_RUN];
            sel_q  <= bus_wdata[SEL_W-1:0];
         end
         if (hit_zero)     zf_q <= 1'b1;
         else if (wr_ctrl) zf_q <= bus_wdata[BIT_ZF];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_COUNT: bus_rdata[CNT_W-1:0] = cnt;
         ADDR_PRESC: bus_rdata[PSC_W-1:0] = psc;
         ADDR_CTRL: begin
            bus_rdata[BIT_ZF]      = zf_q;
            bus_rdata[BIT_IE]      = ie_q;
            bus_rdata[BIT_MODE]    = mode_q;
            bus_rdata[BIT_EXT]     = ext_q;
            bus_rdata[BIT_RUN]     = run_q;
            bus_rdata[SEL_W-1:0]   = sel_q;
         end
         default: bus_rdata = '0;
      endcase
   end

   assign irq = zf_q & ie_q;

   assert_zf_cause_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(zf_q) |-> (cnt == '0 || $past(wr_ctrl)));
   assert_zf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (zf_q && !wr_ctrl) |=> zf_q);
   assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
      irq |-> (zf_q && ie_q));
endmodule

// File: tb/tick_down_timer_tb_top.sv
`timescale 1ns/1ps
module tick_down_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tmr_pin = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tick_down_timer dut_i (
      .clk(clk), .rst(rst), .tmr_pin(tmr_pin), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   // sel, input pulses, expected counter (from 20h), expected prescaler (from 7Fh)
   typedef struct packed {
      logic [2:0] sel;
      logic [7:0] pulses;
      logic [7:0] exp_cnt;
      logic [7:0] exp_psc;
   } vec_t;
   localparam vec_t VECS [8] = '{
      '{3'd0, 8'd5,   8'h1B, 8'h7A},
      '{3'd1, 8'd6,   8'h1D, 8'h79},
      '{3'd2, 8'd9,   8'h1E, 8'h76},
      '{3'd3, 8'd16,  8'h1E, 8'h6F},
      '{3'd4, 8'd33,  8'h1E, 8'h5E},
      '{3'd5, 8'd64,  8'h1E, 8'h3F},
      '{3'd6, 8'd70,  8'h1F, 8'h39},
      '{3'd7, 8'd130, 8'h1F, 8'h7D}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tmr_pin = 1'b1;
         repeat (4) @(negedge clk);
         tmr_pin = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      rd(2'd0, d); check("R1 counter", d, 8'h00);
      rd(2'd2, d); check("R1 control", d, 8'h00);
      rd(2'd1, d); check("R1 prescaler", d, 8'h7F);
      check("R1 irq", {7'b0, irq}, 8'h00);

      // R3 R4 R5: vector table, external source
      foreach (VECS[i]) begin
         wr(2'd2, {5'b00010, VECS[i].sel});
         wr(2'd0, 8'h20);
         wr(2'd2, {5'b00011, VECS[i].sel});
         pulses(VECS[i].pulses);
         rd(2'd0, d); check($sformatf("R5 counter sel %0d", VECS[i].sel), d, VECS[i].exp_cnt);
         rd(2'd1, d); check($sformatf("R3 prescaler sel %0d", VECS[i].sel), d, VECS[i].exp_psc);
      end

      // R6 run cleared: frozen, prescaler write ignored
      wr(2'd2, 8'h10);
      wr(2'd0, 8'h33);
      wr(2'd1, 8'h12);
      rd(2'd1, d); check("R6 prescaler write ignored", d, 8'h7F);
      pulses(3);
      rd(2'd0, d); check("R6 counter frozen", d, 8'h33);
      rd(2'd1, d); check("R6 prescaler parked", d, 8'h7F);

      // R7 prescaler load while running, then R3 step
      wr(2'd2, 8'h18);
      wr(2'd1, 8'h12);
      rd(2'd1, d); check("R7 prescaler load", d, 8'h12);
      pulses(1);
      rd(2'd1, d); check("R3 prescaler step", d, 8'h11);
      rd(2'd0, d); check("R2 counter after one edge", d, 8'h32);

      // R8 R9 zero flag, wrap, interrupt
      wr(2'd2, 8'h10);
      wr(2'd0, 8'h02);
      wr(2'd2, 8'h18);
      pulses(2);
      rd(2'd0, d); check("R8 counter at zero", d, 8'h00);
      rd(2'd2, d); check("R8 zero flag set", d, 8'h98);
      check("R9 irq disabled", {7'b0, irq}, 8'h00);
      wr(2'd2, 8'hF8);
      check("R9 irq raised", {7'b0, irq}, 8'h01);
      pulses(1);
      rd(2'd0, d); check("R8 wrap", d, 8'hFF);
      rd(2'd2, d); check("R8 flag sticky, R9 mode bit", d, 8'hF8);
      wr(2'd2, 8'h58);
      check("R9 irq cleared", {7'b0, irq}, 8'h00);
      rd(2'd2, d); check("R8 flag cleared", d, 8'h58);

      // R4 internal divide-by-12 source, pin ignored
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h40);
      wr(2'd2, 8'h08);
      fork
         pulses(10);
         repeat (240) @(negedge clk);
      join
      rd(2'd0, d);
      n_chk++;
      if (d < 8'h2B || d > 8'h2D) begin
         n_bad++;
         $display("FAIL R4 internal source: actual %h expected 2B..2D", d);
      end
      finish_run();
   end
endmodule